// File: doc/BRIEF.md
# Buffered Serial Transfer Engine with Inter-Byte Gaps

This block moves a run of bytes through a clocked serial link without software touching each byte. A 32-entry byte buffer holds the data. Two 5-bit pointer registers, a first-entry register and a last-entry register, mark the part of the buffer that one transfer covers. Once started, the engine shifts each byte out least significant bit first on SDO. At the same time it shifts a byte in from SDI and writes the received byte back into the entry it just sent. The serial clock is generated internally from the system clock.

A control register holds two fields. The divider field sets the serial clock rate. The gap field sets an optional idle stretch between bytes, during which SCK stays high and a strobe output marks the byte boundary. Software loads the buffer, programs the three registers and writes a start command. It then polls the status register until the done flag rises.

The register port has four word addresses. Address 0 is the first-entry register, address 1 is the last-entry register, address 2 is the control register (gap field in bits 4:3, divider field in bits 2:0), and address 3 is the command and status register. Writing bit 0 of address 3 starts a transfer. Reading address 3 returns busy in bit 0 and done in bit 1.

Top module: `gapped_serial_xfer`

## Requirements
- R1: After reset, address 0 reads 0x00, addresses 1 and 2 read 0xE0, address 3 reads 0x00, SCK is high and STRB is low.
- R2: Bits 7:5 of addresses 1 and 2 always read 1 and ignore writes. Bits 7:5 of address 0 always read 0. For example, writing 0x03 to address 1 reads back 0xE3, and writing 0xFF to address 0 reads back 0x1F.
- R3: A transfer covers every entry from the first pointer to the last pointer inclusive, in ascending order. When the last pointer is below the first, the walk wraps from entry 31 to entry 0. Equal pointers give exactly one byte. Entries outside the range are not modified.
- R4: Bits leave on SDO least significant bit first. SDO changes only where SCK falls, and SDI is sampled where SCK rises. The byte received during a transfer slot is written back to the same buffer entry.
- R5: With divider code n (0 to 7), one SCK period spans 2^(n+1) system clock cycles, so each byte occupies 16·2^n cycles.
- R6: Gap codes 0, 1, 2 and 3 insert 0, 8, 24 and 56 SCK periods of idle time after every byte, the last byte included. SCK stays high throughout the gap.
- R7: When the gap is nonzero, STRB is high for exactly the first SCK period of each gap. With gap code 0, STRB stays low for the whole transfer.
- R8: The start command clears done and sets busy. Done rises and busy falls exactly nb·(16 + 2·G)·2^n cycles after the cycle in which the start command is accepted, where nb is the byte count, G is the gap length in SCK periods and n is the divider code.
- R9: While busy, writes to the pointer registers, the control register and the buffer are ignored, and a further start command has no effect.
- R10: SCK is high whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| buf_wr | input | 1 | Buffer write strobe from software |
| buf_addr | input | 5 | Buffer entry for software access |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer contents at buf_addr |
| sck | output | 1 | Serial clock, idle high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| strb | output | 1 | Byte boundary strobe |
| done | output | 1 | Transfer finished flag |
| busy | output | 1 | Transfer in progress |

## Verification
The bench keeps the default parameters: 5-bit pointers, 8-bit data and a 3-bit divider field. At these sizes the complete buffer, every gap code and every divider code can be exercised within a short run. It sweeps all four gap codes against the three fastest dividers over a single-byte range, an ascending range and a wrapping range. It then runs the five slow dividers, a full 32-entry pass and a full wrapping pass, and finally a run that is poked with writes while busy. SDI is looped back as the inverse of SDO, so every written-back entry has a known value that is checked across all 32 entries after each run.

// File: rtl/gsx_pkg.sv
package gsx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } xfer_state_e;

  localparam int GAP_W       = 2;
  localparam int GAP_MAX_PER = 56;
  localparam int GCNT_W      = $clog2(2 * GAP_MAX_PER);

  localparam logic [1:0] RA_FIRST = 2'd0;
  localparam logic [1:0] RA_LAST  = 2'd1;
  localparam logic [1:0] RA_CTRL  = 2'd2;
  localparam logic [1:0] RA_CMD   = 2'd3;

  // Gap length in half SCK periods: 0, 16, 48, 112
  function automatic logic [GCNT_W-1:0] gap_halves(input logic [GAP_W-1:0] sel);
    int per;
    per = (8 << sel) - 8;
    return GCNT_W'(2 * per);
  endfunction

endpackage

// File: rtl/gsx_regs.sv
module gsx_regs
  import gsx_pkg::*;
#(
  parameter int AW    = 5,
  parameter int DW    = 8,
  parameter int CKS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic             lock,
  input  logic             stat_busy,
  input  logic             stat_done,
  output logic [AW-1:0]    first_q,
  output logic [AW-1:0]    last_q,
  output logic [GAP_W-1:0] gap_q,
  output logic [CKS_W-1:0] cks_q,
  output logic             go,
  output logic [DW-1:0]    rdata
);

  localparam int CTL_W = GAP_W + CKS_W;

  logic [AW-1:0]    first_d, last_d;
  logic [GAP_W-1:0] gap_d;
  logic [CKS_W-1:0] cks_d;
  logic             wr_ok;
  logic             unused_hi;

  assign wr_ok     = wr_en && !lock;
  assign go        = wr_ok && (addr == RA_CMD) && wdata[0];
  assign unused_hi = ^wdata[DW-1:AW];

  always_comb begin
    first_d = first_q;
    last_d  = last_q;
    gap_d   = gap_q;
    cks_d   = cks_q;
    if (wr_ok) begin
      case (addr)
        RA_FIRST: first_d = wdata[AW-1:0];
        RA_LAST:  last_d  = wdata[AW-1:0];
        RA_CTRL:  {gap_d, cks_d} = wdata[CTL_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      gap_q   <= '0;
      cks_q   <= '0;
    end else begin
      first_q <= first_d;
      last_q  <= last_d;
      gap_q   <= gap_d;
      cks_q   <= cks_d;
    end
  end

  always_comb begin
    case (addr)
      RA_FIRST: begin
        rdata = '0;
        rdata[AW-1:0] = first_q;
      end
      RA_LAST: begin
        rdata = '1;
        rdata[AW-1:0] = last_q;
      end
      RA_CTRL: begin
        rdata = '1;
        rdata[CTL_W-1:0] = {gap_q, cks_q};
      end
      default: begin
        rdata = '0;
        rdata[1:0] = {stat_done, stat_busy};
      end
    endcase
  end

endmodule

// File: rtl/gsx_baud.sv
module gsx_baud #(
  parameter int CKS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CKS_W-1:0] cks,
  output logic             tick
);

  localparam int CNT_W = (1 << CKS_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, mask;

  assign mask = CNT_W'((64'd1 << cks) - 64'd1);
  assign tick = en && (cnt_q == mask);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/gsx_buffer.sv
module gsx_buffer #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_sw,
  output logic [DW-1:0] rd_sw,
  input  logic [AW-1:0] ra_eng,
  output logic [DW-1:0] rd_eng
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_sw  = mem[ra_sw];
  assign rd_eng = mem[ra_eng];

endmodule

// File: rtl/gsx_shifter.sv
module gsx_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          shift,
  input  logic          sample,
  input  logic          sdi,
  output logic          sdo,
  output logic [DW-1:0] rx
);

  logic [DW-1:0] tx_q, tx_d, rx_d;

  always_comb begin
    if (load)       tx_d = load_data;
    else if (shift) tx_d = tx_q >> 1;
    else            tx_d = tx_q;
    rx_d = sample ? {sdi, rx[DW-1:1]} : rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx   <= '0;
    end else begin
      tx_q <= tx_d;
      rx   <= rx_d;
    end
  end

  assign sdo = tx_q[0];

endmodule

// File: rtl/gapped_serial_xfer.sv
module gapped_serial_xfer
  import gsx_pkg::*;
#(
  parameter int AW    = 5,
  parameter int DW    = 8,
  parameter int CKS_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          buf_wr,
  input  logic [AW-1:0] buf_addr,
  input  logic [DW-1:0] buf_wdata,
  output logic [DW-1:0] buf_rdata,
  output logic          sck,
  output logic          sdo,
  input  logic          sdi,
  output logic          strb,
  output logic          done,
  output logic          busy
);

  localparam int                HALF_W    = $clog2(2 * DW);
  localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(2 * DW - 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  xfer_state_e       state_q, state_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic [GCNT_W-1:0] gcnt_q, gcnt_d;
  logic              done_q, done_d;

  logic [AW-1:0]     first_addr, last_addr;
  logic [GAP_W-1:0]  gap_sel;
  logic [CKS_W-1:0]  cks_sel;
  logic              go, tick, busy_w, at_last;
  logic              load, shift, sample, eng_we;
  logic [AW-1:0]     eng_raddr, mem_waddr;
  logic [DW-1:0]     eng_rdata, rx_byte, mem_wdata;
  logic              mem_we;

  assign busy_w  = (state_q != ST_IDLE);
  assign at_last = (ptr_q == last_addr);

  gsx_regs #(.AW(AW), .DW(DW), .CKS_W(CKS_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .lock      (busy_w),
    .stat_busy (busy_w),
    .stat_done (done_q),
    .first_q   (first_addr),
    .last_q    (last_addr),
    .gap_q     (gap_sel),
    .cks_q     (cks_sel),
    .go        (go),
    .rdata     (reg_rdata)
  );

  gsx_baud #(.CKS_W(CKS_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_sn),
    .en    (busy_w),
    .cks   (cks_sel),
    .tick  (tick)
  );

  assign eng_raddr = (state_q == ST_IDLE) ? first_addr : ptr_q + 1'b1;
  assign mem_we    = eng_we || (buf_wr && !busy_w);
  assign mem_waddr = eng_we ? ptr_q   : buf_addr;
  assign mem_wdata = eng_we ? rx_byte : buf_wdata;

  gsx_buffer #(.AW(AW), .DW(DW)) u_buf (
    .clk    (clk),
    .we     (mem_we),
    .waddr  (mem_waddr),
    .wdata  (mem_wdata),
    .ra_sw  (buf_addr),
    .rd_sw  (buf_rdata),
    .ra_eng (eng_raddr),
    .rd_eng (eng_rdata)
  );

  gsx_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sn),
    .load      (load),
    .load_data (eng_rdata),
    .shift     (shift),
    .sample    (sample),
    .sdi       (sdi),
    .sdo       (sdo),
    .rx        (rx_byte)
  );

  // sequencer next state
  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    half_d  = half_q;
    gcnt_d  = gcnt_q;
    done_d  = done_q;
    load    = 1'b0;
    shift   = 1'b0;
    sample  = 1'b0;
    eng_we  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d = ST_SHIFT;
          ptr_d   = first_addr;
          half_d  = '0;
          done_d  = 1'b0;
          load    = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!half_q[0]) begin
            sample = 1'b1;
            half_d = half_q + 1'b1;
          end else if (half_q == LAST_HALF) begin
            eng_we = 1'b1;
            if (gap_sel != '0) begin
              state_d = ST_GAP;
              gcnt_d  = '0;
            end else if (at_last) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              ptr_d  = ptr_q + 1'b1;
              half_d = '0;
              load   = 1'b1;
            end
          end else begin
            shift  = 1'b1;
            half_d = half_q + 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (gcnt_q == gap_halves(gap_sel) - 1'b1) begin
            if (at_last) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              state_d = ST_SHIFT;
              ptr_d   = ptr_q + 1'b1;
              half_d  = '0;
              load    = 1'b1;
            end
          end else begin
            gcnt_d = gcnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      half_q  <= '0;
      gcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      half_q  <= half_d;
      gcnt_q  <= gcnt_d;
      done_q  <= done_d;
    end
  end

  assign sck  = (state_q == ST_SHIFT) ? half_q[0] : 1'b1;
  assign strb = (state_q == ST_GAP) && (gcnt_q < GCNT_W'(2));
  assign done = done_q;
  assign busy = busy_w;

endmodule

// File: rtl/gsx_checker.sv
module gsx_checker #(
  parameter int GW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          sck,
  input logic          sdo,
  input logic          strb,
  input logic          tick,
  input logic [GW-1:0] gap_sel
);

  assert_idle_sck_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck);

  assert_gap_sck_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> (sck && busy));

  assert_no_strobe_nogap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_sel == '0) |-> !strb);

  assert_sdo_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(sdo)) |-> $fell(sck));

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_sck_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sck) && $past(busy)) |-> $past(tick));

endmodule

bind gapped_serial_xfer gsx_checker #(.GW(gsx_pkg::GAP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sn),
  .busy    (busy_w),
  .done    (done_q),
  .sck     (sck),
  .sdo     (sdo),
  .strb    (strb),
  .tick    (tick),
  .gap_sel (gap_sel)
);

// File: tb/sim_gapped_serial_xfer.sv
module sim_gapped_serial_xfer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       buf_wr = 1'b0;
  logic [4:0] buf_addr = 5'd0;
  logic [7:0] buf_wdata = 8'd0;
  logic [7:0] buf_rdata;
  logic       sck, sdo, sdi, strb, done, busy;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_mem [32];

  always #4 clk = ~clk;

  assign sdi = ~sdo;

  gapped_serial_xfer u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .buf_wr(buf_wr), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .sck(sck), .sdo(sdo), .sdi(sdi), .strb(strb), .done(done), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic buf_check(input string tag);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      buf_addr = 5'(i);
      #1 check(tag, int'(buf_rdata), int'(exp_mem[i]));
    end
  endtask

  task automatic do_xfer(input int st, input int en, input int g, input int n, input bit poke);
    int nb, cnt, falls, strbs, bitc, exp_t, idx;
    logic [7:0] cur, rd;
    logic prev;
    nb    = ((en - st + 32) % 32) + 1;
    exp_t = nb * (16 << n) + ((g != 0) ? nb * 2 * ((8 << g) - 8) * (1 << n) : 0);
    reg_write(2'd2, 8'((g << 3) | n));
    reg_write(2'd0, 8'(st));
    reg_write(2'd1, 8'(en));
    cnt = 0; falls = 0; strbs = 0; bitc = 0; cur = 8'd0; prev = 1'b1;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'd1;
    do begin
      @(negedge clk);
      reg_wr = 1'b0; buf_wr = 1'b0;
      cnt++;
      if (poke && cnt == 5) begin
        buf_wr = 1'b1; buf_addr = 5'd10; buf_wdata = 8'h5A;
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h1F;
      end
      if (poke && cnt == 7) begin
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'd1;
      end
      if (strb) strbs++;
      if (prev && !sck) falls++;
      if (!prev && sck) begin
        cur[bitc % 8] = sdo;
        bitc++;
        if (bitc % 8 == 0) begin
          idx = (st + bitc / 8 - 1) % 32;
          check("R4 serial byte LSB first", int'(cur), int'(exp_mem[idx]));
        end
      end
      prev = sck;
    end while (!done && cnt < exp_t + 200);
    // R8 / R5 / R6: completion time
    check("R8 cycles to done", cnt, exp_t + 1);
    check("R3 falling SCK edges", falls, 8 * nb);
    check("R7 strobe cycles", strbs, (g != 0) ? nb * 2 * (1 << n) : 0);
    check("R10 SCK idle high", int'(sck), 1);
    reg_read(2'd3, rd);
    check("R8 status done/not busy", int'(rd), 2);
    if (poke) begin
      reg_read(2'd2, rd);
      check("R9 control locked while busy", int'(rd), 8'hE0 | ((g << 3) | n));
    end
    for (int k = 0; k < nb; k++) exp_mem[(st + k) % 32] = ~exp_mem[(st + k) % 32];
    buf_check("R3 R4 buffer writeback");
  endtask

  initial begin : watchdog
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_read(2'd0, rd); check("R1 first reg reset", int'(rd), 8'h00);
    reg_read(2'd1, rd); check("R1 last reg reset", int'(rd), 8'hE0);
    reg_read(2'd2, rd); check("R1 ctrl reset", int'(rd), 8'hE0);
    reg_read(2'd3, rd); check("R1 status reset", int'(rd), 8'h00);
    check("R1 SCK high", int'(sck), 1);
    check("R1 STRB low", int'(strb), 0);

    // R2 reserved bits
    reg_write(2'd1, 8'h03); reg_read(2'd1, rd); check("R2 last reserved", int'(rd), 8'hE3);
    reg_write(2'd2, 8'h1B); reg_read(2'd2, rd); check("R2 ctrl reserved", int'(rd), 8'hFB);
    reg_write(2'd2, 8'h00); reg_read(2'd2, rd); check("R2 ctrl cleared", int'(rd), 8'hE0);
    reg_write(2'd0, 8'hFF); reg_read(2'd0, rd); check("R2 first upper zero", int'(rd), 8'h1F);

    // load buffer
    for (int i = 0; i < 32; i++) begin
      exp_mem[i] = 8'(i * 37 + 5);
      @(negedge clk);
      buf_wr = 1'b1; buf_addr = 5'(i); buf_wdata = exp_mem[i];
    end
    @(negedge clk); buf_wr = 1'b0;
    buf_check("R3 buffer load");

    // R3 R5 R6 R7 sweep: gap codes x fast dividers x ranges
    for (int g = 0; g < 4; g++)
      for (int n = 0; n < 3; n++) begin
        do_xfer(5, 5, g, n, 1'b0);
        do_xfer(3, 7, g, n, 1'b0);
        do_xfer(30, 1, g, n, 1'b0);
      end

    // R5 slow dividers
    for (int n = 3; n < 8; n++) do_xfer(7, 7, 0, n, 1'b0);
    do_xfer(12, 13, 1, 3, 1'b0);

    // R3 full buffer, straight and wrapped
    do_xfer(0, 31, 0, 0, 1'b0);
    do_xfer(16, 15, 0, 0, 1'b0);

    // R9 writes ignored while busy
    do_xfer(0, 1, 1, 0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule